// File: doc/BRIEF.md
# Early-Terminating Iterative Divider

This block is a multicycle integer divider for the second execute stage of an in-order pipeline. A one-cycle `start` strobe hands it a dividend, a divisor and a signed/unsigned select. It raises `busy` for a number of cycles that depends on the operands, and the pipeline holds everything behind the divide for as long as `busy` is high. When the result is ready, `done` pulses and the quotient and remainder appear on their ports. They stay there until the next result replaces them.

The iteration count depends on how many significant bits the dividend's magnitude has. One overhead cycle counts the leading zeros and left-aligns the magnitude. One restoring step then runs for each significant bit. A final overhead cycle applies the signs. Small dividends therefore finish early, and a zero dividend needs only the two overhead cycles.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` seen while `busy` is low raises `busy` in the next cycle. `busy` then stays high for exactly (32 − leading zeros of the dividend's magnitude) + 2 cycles. The magnitude is the two's-complement absolute value when `signedMode`=1 and the dividend is negative; otherwise it is the dividend itself.
- R3: A dividend whose magnitude has bit 31 set (for example 0xFFFFFFFF unsigned, or 0x80000000 signed) takes the maximum of 34 busy cycles. No operation is longer.
- R4: A zero dividend with a nonzero divisor takes 2 busy cycles and gives quotient 0 and remainder 0.
- R5: With `signedMode`=0, the quotient is the floor of dividend/divisor and the remainder is dividend − quotient×divisor, all unsigned.
- R6: With `signedMode`=1, the operands are two's complement. The quotient truncates toward zero and is negative when the operand signs differ. The remainder takes the dividend's sign.
- R7: A zero divisor completes in the R2 cycle count. It gives quotient 0xFFFFFFFF and returns the unmodified dividend as the remainder, in either mode.
- R8: `done` is a single-cycle pulse in the cycle right after the last busy cycle, and the results are valid in that cycle. `quotient` and `remainder` keep their values until the next `done`.
- R9: A `start` asserted while `busy` is high is ignored. The operation in flight keeps its operands, its cycle count and its result.
- R10: The signed division 0x80000000 / 0xFFFFFFFF wraps to quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a division; sampled only while idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled with `start` |
| divisor | input | 32 | Divisor, sampled with `start` |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |
| busy | output | 1 | High while a division occupies the stage (stall) |
| done | output | 1 | One-cycle pulse when new results are present |

## Verification
The start edge loads the operands. `busy` is high from the following cycle for the count in R2, so the bench expects `done` and the results in cycle count+1 after `start`. The bench samples on falling edges. It counts the falling edges at which `busy` is high and compares that count with a leading-zero count it computes itself. At the first falling edge with `busy` low, it checks `done`, the quotient and the remainder against wide-integer reference arithmetic. One falling edge later it checks that `done` has dropped and the results have held. Random operands have random magnitudes so that every latency from 2 to 34 occurs. Directed cases cover zero dividend, zero divisor, signed overflow and a `start` asserted in mid-operation.

// File: rtl/div_pkg.sv
package div_pkg;
  // Strobes from the sequencer to the datapath, one per phase
  typedef struct packed {
    logic load;   // capture operands
    logic norm;   // magnitude, leading-zero count, alignment
    logic step;   // one restoring iteration
    logic fix;    // sign correction and result update
  } divStrobe_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNTW = $clog2(WIDTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CNTW-1:0] bitLen,
  output divStrobe_t      strobe,
  output logic            busy,
  output logic            done
);
  typedef enum logic [1:0] {S_IDLE, S_NORM, S_ITER, S_FIX} divState_e;

  divState_e       state;
  logic [CNTW-1:0] iterLeft;

  always_comb begin
    strobe.load = (state == S_IDLE) && start;
    strobe.norm = (state == S_NORM);
    strobe.step = (state == S_ITER);
    strobe.fix  = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.fix;
      unique case (state)
        S_IDLE: if (start) state <= S_NORM;
        S_NORM: begin
          iterLeft <= bitLen;
          state    <= (bitLen == '0) ? S_FIX : S_ITER;
        end
        S_ITER: begin
          iterLeft <= iterLeft - 1'b1;
          if (iterLeft == CNTW'(1)) state <= S_FIX;
        end
        S_FIX:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Length of the current busy run, kept for the latency bound check
  logic [CNTW:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R2
  AST_MAX_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < (CNTW+1)'(WIDTH + 2))); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(busy))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (state != S_NORM)); // R9
endmodule

// File: rtl/div_path.sv
module div_path
  import div_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNTW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [CNTW-1:0]  bitLen,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic [WIDTH-1:0] opA, opB, mag, dvs, quo, qOut, rOut;
  logic [WIDTH:0]   rem;
  logic             sgn;

  function automatic int leadZeros(input logic [WIDTH-1:0] v);
    int n = WIDTH;
    for (int i = 0; i < WIDTH; i++)
      if (v[i]) n = WIDTH - 1 - i;
    return n;
  endfunction

  logic [WIDTH-1:0] absA, absB;
  int               lz;
  logic [WIDTH:0]   trial;
  logic             fits;

  always_comb begin
    absA   = (sgn && opA[WIDTH-1]) ? (~opA + 1'b1) : opA;
    absB   = (sgn && opB[WIDTH-1]) ? (~opB + 1'b1) : opB;
    lz     = leadZeros(absA);
    bitLen = CNTW'(WIDTH - lz);
    trial  = {rem[WIDTH-1:0], mag[WIDTH-1]};
    fits   = (trial >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA <= '0; opB <= '0; sgn <= 1'b0;
      mag <= '0; dvs <= '0; rem <= '0; quo <= '0;
      qOut <= '0; rOut <= '0;
    end else begin
      if (strobe.load) begin
        opA <= dividend;
        opB <= divisor;
        sgn <= signedMode;
      end
      if (strobe.norm) begin
        mag <= absA << lz;
        dvs <= absB;
        rem <= '0;
        quo <= '0;
      end
      if (strobe.step) begin
        mag <= mag << 1;
        rem <= fits ? (trial - {1'b0, dvs}) : trial;
        quo <= {quo[WIDTH-2:0], fits};
      end
      if (strobe.fix) begin
        if (opB == '0) begin
          qOut <= '1;
          rOut <= opA;
        end else begin
          qOut <= (sgn && (opA[WIDTH-1] ^ opB[WIDTH-1])) ? (~quo + 1'b1) : quo;
          rOut <= (sgn && opA[WIDTH-1]) ? (~rem[WIDTH-1:0] + 1'b1) : rem[WIDTH-1:0];
        end
      end
    end
  end

  assign quotient  = qOut;
  assign remainder = rOut;

  AST_DIVZERO_QUO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fix && opB == '0) |=> (quotient == '1 && remainder == $past(opA))); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fix |=> ($stable(quotient) && $stable(remainder))); // R8
  AST_PARTIAL_REM: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && dvs != '0) |=> (rem < {1'b0, dvs})); // R5
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             busy,
  output logic             done
);
  localparam int CNTW = $clog2(WIDTH + 1);

  divStrobe_t      strobe;
  logic [CNTW-1:0] bitLen;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bitLen(bitLen),
    .strobe(strobe), .busy(busy), .done(done)
  );

  div_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .bitLen(bitLen),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: tb/iter_divider_bench.sv
module iter_divider_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic [31:0] quotient, remainder;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  iter_divider u_iter_divider (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expLatency(input logic [31:0] a, input bit s);
    logic [31:0] m = (s && a[31]) ? (~a + 1) : a;
    int n = 32;
    for (int i = 0; i < 32; i++) if (m[i]) n = 31 - i;
    return 32 - n + 2;
  endfunction

  function automatic void expResult(input logic [31:0] a, input logic [31:0] b,
                                    input bit s, output logic [31:0] q,
                                    output logic [31:0] r);
    if (b == 0) begin
      q = '1; r = a;
    end else if (s) begin
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
    end else begin
      longint ua = longint'({32'd0, a});
      longint ub = longint'({32'd0, b});
      q = 32'(ua / ub);
      r = 32'(ua % ub);
    end
  endfunction

  task automatic runDiv(input logic [31:0] a, input logic [31:0] b,
                        input bit s, input bit poke, input bit holdChk);
    logic [31:0] eq, er;
    int lat, n;
    string latTag, resTag;
    expResult(a, b, s, eq, er);
    lat = expLatency(a, s);
    latTag = (a == 0) ? "R4" : (lat == 34) ? "R3" : "R2";
    if (b == 0) resTag = "R7";
    else if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) resTag = "R10";
    else if (a == 0) resTag = "R4";
    else if (poke) resTag = "R9";
    else resTag = s ? "R6" : "R5";
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; signedMode = s;
    @(negedge clk);
    start = 1'b0; dividend = $urandom; divisor = $urandom; signedMode = $urandom;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (poke && n == 2) begin
        start = 1'b1; dividend = 32'h0000_0003; divisor = 32'h0000_0007;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(poke ? "R9" : latTag, "busy cycles", n, lat);
    check("R8", "done after busy", done, 1);
    check(resTag, "quotient", quotient, eq);
    check(resTag, "remainder", remainder, er);
    if (holdChk) begin
      @(negedge clk);
      check("R8", "done single pulse", done, 0);
      @(negedge clk);
      check("R8", "quotient held", quotient, eq);
      check("R8", "remainder held", remainder, er);
    end
  endtask

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "busy at reset", busy, 0);
    check("R1", "done at reset", done, 0);
    check("R1", "quotient at reset", quotient, 0);
    check("R1", "remainder at reset", remainder, 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runDiv(32'd0, 32'd5, 1'b0, 1'b0, 1'b1);
    runDiv(32'd100, 32'd7, 1'b0, 1'b0, 1'b1);
    runDiv(32'hFFFF_FFFF, 32'd3, 1'b0, 1'b0, 1'b0);
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    runDiv(32'h8000_0000, 32'd1, 1'b1, 1'b0, 1'b0);
    runDiv(32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0, 1'b0);
    runDiv(32'd7, 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
    runDiv(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
    runDiv(32'd12345, 32'd0, 1'b0, 1'b0, 1'b1);
    runDiv(32'hFFFF_FF00, 32'd0, 1'b1, 1'b0, 1'b0);
    runDiv(32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    runDiv(32'h00FF_1234, 32'd13, 1'b0, 1'b1, 1'b1);
    runDiv(32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    // random operands with random magnitudes
    for (int i = 0; i < 300; i++) begin
      a = $urandom >> ($urandom % 33);
      b = $urandom >> ($urandom % 33);
      if (($urandom % 16) == 0) b = '0;
      runDiv(a, b, 1'($urandom), 1'(($urandom % 20) == 0), 1'b0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule